// File: doc/BRIEF.md
# N-Queens Backtracking Search Engine

This block searches for one placement of N queens on an N by N board so that no queen attacks another. Each column holds one queen's row. A single token marks the column that is active. Only that column may move its queen, and it tests one candidate row per clock. When the candidate is safe against every queen to its left, the queen is placed and the token moves one column to the right. When the column runs out of rows, its queen is removed and the token steps back one column to the left. The column it returns to then resumes from its next row. The token's moves therefore do the work of a software recursion stack.

The search is launched with a start pulse. When it ends, either the solved flag or the no-solution flag stays high, and the board read-out holds the placement. Both flags persist until the next start. Candidates are always tried in ascending row order, so the result is the lexicographically first solution, with column 0 as the most significant position.

Top module: `nq_solver`

## Requirements
- R1: After reset, busy, solved and no_solution are low, and every bit of placed and rows is 0.
- R2: A start pulse while busy is low takes effect at the next clock edge. After that edge, busy is high, both flags are low, placed is 0, and the token is on column 0 with candidate row 0.
- R3: A start pulse while busy is high has no effect. The final placement and the number of cycles to completion are unchanged.
- R4: Only the token's column can change its queen (rows field or placed bit) at a clock edge, and that column tests exactly one candidate row per clock.
- R5: When the token enters a column moving right, the column starts at row 0. When it enters moving left, the column resumes at its current row plus one. Row i of the result is rows[i*W +: W], with W = max(1, ceil(log2 N)). The result is the lexicographically first solution. It is reached exactly S cycles after the start edge, where S is the number of candidate tests plus backtrack steps in this search order.
- R6: A candidate is accepted only if no queen in a column to its left has the same row, or a row difference whose magnitude equals the column distance.
- R7: A column that steps past row N-1 clears its queen (placed bit 0, row 0) and hands the token left. While busy, no column to the right of the token holds a queen.
- R8: When column N-1 accepts a row, solved rises and busy falls at the same edge, with all N placed bits set.
- R9: When column 0 runs out of rows, no_solution rises and busy falls at the same edge, and the board is empty (for N = 2 and N = 3).
- R10: solved and no_solution are never high together, and each holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new search; ignored while busy |
| busy | output | 1 | Search in progress |
| solved | output | 1 | A full placement was found |
| no_solution | output | 1 | The search space is exhausted with no placement |
| placed | output | N | One bit per column; set when that column holds a queen |
| rows | output | N*W | Row of each column's queen; column i in bits [i*W +: W] |

## Verification
The embedded properties check, on every cycle, the following:
- only the token's column alters its queen;
- the columns to the right of the token are empty;
- the board is full when solved is high and empty when no_solution is high;
- the two flags never overlap, and each persists;
- a start accepted while idle clears the state.

The scenarios for board sizes 1 through 8 show what a single cycle cannot. They confirm that the final placement is the lexicographically first legal one, that the exact cycle count matches the ascending search order, and that a start pulse during the search leaves both unchanged.

// File: rtl/nq_solver.sv
module nq_solver #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           solved,
  output logic           no_solution,
  output logic [N-1:0]   placed,
  output logic [N*W-1:0] rows
);

  logic [W-1:0]  row_q [N];
  logic [N-1:0]  placed_q;
  logic [W-1:0]  tok;
  logic [CW-1:0] cand;
  logic          busy_q, solved_q, none_q;
  logic          safe, exhausted, at_first, at_last;
  logic [W-1:0]  prv;
  logic [N-1:0]  right_of_tok;

  assign exhausted = (cand == CW'(N));
  assign at_first  = (tok == '0);
  assign at_last   = (tok == W'(N - 1));
  assign prv       = at_first ? '0 : tok - 1'b1;

  always_comb begin
    safe = 1'b1;
    for (int j = 0; j < N; j++) begin
      if (j < int'(tok)) begin
        if (int'(row_q[j]) == int'(cand) ||
            int'(row_q[j]) - int'(cand) == int'(tok) - j ||
            int'(cand) - int'(row_q[j]) == int'(tok) - j)
          safe = 1'b0;
      end
    end
  end

  always_comb
    for (int i = 0; i < N; i++) right_of_tok[i] = (i > int'(tok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) row_q[i] <= '0;
      placed_q <= '0;
      tok      <= '0;
      cand     <= '0;
      busy_q   <= 1'b0;
      solved_q <= 1'b0;
      none_q   <= 1'b0;
    end else if (start && !busy_q) begin
      for (int i = 0; i < N; i++) row_q[i] <= '0;
      placed_q <= '0;
      tok      <= '0;
      cand     <= '0;
      busy_q   <= 1'b1;
      solved_q <= 1'b0;
      none_q   <= 1'b0;
    end else if (busy_q) begin
      if (exhausted) begin
        row_q[tok]    <= '0;
        placed_q[tok] <= 1'b0;
        if (at_first) begin
          busy_q <= 1'b0;
          none_q <= 1'b1;
        end else begin
          tok  <= prv;
          cand <= CW'(row_q[prv]) + 1'b1;
        end
      end else if (safe) begin
        row_q[tok]    <= cand[W-1:0];
        placed_q[tok] <= 1'b1;
        if (at_last) begin
          busy_q   <= 1'b0;
          solved_q <= 1'b1;
        end else begin
          tok  <= tok + 1'b1;
          cand <= '0;
        end
      end else begin
        cand <= cand + 1'b1;
      end
    end
  end

  assign busy        = busy_q;
  assign solved      = solved_q;
  assign no_solution = none_q;
  assign placed      = placed_q;

  for (genvar i = 0; i < N; i++) begin : g_out
    assign rows[i*W +: W] = row_q[i];

    p_holder_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(row_q[i]) || !$stable(placed_q[i])) |->
        (($past(busy_q) && $past(tok) == W'(i)) || $past(start && !busy_q)));
  end

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && !solved_q && !none_q && placed_q == '0 && tok == '0));

  p_right_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((placed_q & right_of_tok) == '0));

  p_solved_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    solved_q |-> (&placed_q && !busy_q));

  p_none_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    none_q |-> (placed_q == '0 && !busy_q));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(solved_q && none_q));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((solved_q || none_q) && !start) |=> (solved_q == $past(solved_q) && none_q == $past(none_q)));

endmodule

// File: tb/nq_solver_test.sv
module nq_solver_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   errors = 0;
  int   done_cnt = 0;

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  end

  for (genvar g = 1; g <= 8; g++) begin : g_size
    localparam int N = g;
    localparam int W = (N > 1) ? $clog2(N) : 1;
    logic           start = 1'b0;
    logic           busy, solved, no_solution;
    logic [N-1:0]   placed;
    logic [N*W-1:0] rows;
    int             exp_row [8];
    int             exp_steps;
    bit             exp_found;

    nq_solver #(.N(N)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .solved(solved),
      .no_solution(no_solution), .placed(placed), .rows(rows)
    );

    function automatic int rowat(int c);
      return int'(rows[c*W +: W]);
    endfunction

    task automatic model();
      int t = 0, c = 0;
      exp_steps = 0;
      exp_found = 1'b0;
      for (int k = 0; k < 8; k++) exp_row[k] = 0;
      forever begin
        bit ok = 1'b1;
        exp_steps++;
        if (c == N) begin
          exp_row[t] = 0;
          if (t == 0) break;
          t--;
          c = exp_row[t] + 1;
          continue;
        end
        for (int j = 0; j < t; j++)
          if (exp_row[j] == c || exp_row[j] - c == t - j || c - exp_row[j] == t - j) ok = 1'b0;
        if (ok) begin
          exp_row[t] = c;
          if (t == N - 1) begin exp_found = 1'b1; break; end
          t++;
          c = 0;
        end else c++;
      end
    endtask

    task automatic run(input bit poke);
      int cnt = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy && !solved && !no_solution && placed == '0, "R2 start state", int'(busy), 1);
      while (!solved && !no_solution && cnt < 100000) begin
        @(negedge clk);
        cnt++;
        start = (poke && cnt == 2);
      end
      start = 1'b0;
      chk(cnt == exp_steps, poke ? "R3 cycles with start while busy" : "R5 cycles to finish",
          cnt, exp_steps);
      chk(!busy, "R8/R9 busy falls at finish", int'(busy), 0);
      if (exp_found) begin
        chk(solved && &placed, "R8 solved with full board", int'(placed), (1 << N) - 1);
        for (int i = 0; i < N; i++)
          chk(rowat(i) == exp_row[i], "R5 first solution row", rowat(i), exp_row[i]);
        for (int a = 0; a < N; a++)
          for (int b = a + 1; b < N; b++)
            chk(rowat(a) != rowat(b) && rowat(a) - rowat(b) != b - a && rowat(b) - rowat(a) != b - a,
                "R6 no attack between placed queens", rowat(a) * 16 + rowat(b), -1);
      end else begin
        chk(no_solution && !solved, "R9 no_solution flag", int'(no_solution), 1);
        chk(placed == '0 && rows == '0, "R7 backtracked board cleared", int'(placed), 0);
      end
      repeat (3) @(negedge clk);
      chk(solved == exp_found && no_solution == !exp_found && !(solved && no_solution),
          "R10 flags held and exclusive", int'(solved), int'(exp_found));
    endtask

    initial begin
      model();
      wait (rst_n);
      @(negedge clk);
      chk(!busy && !solved && !no_solution && placed == '0 && rows == '0,
          "R1 reset state", int'(placed), 0);
      run(1'b0);
      run(exp_steps > 4);
      done_cnt++;
    end
  end

  initial begin
    wait (done_cnt == 8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", done_cnt, 8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule